// File: doc/BRIEF.md
# Calibration Switch Sequencer

This controller walks a calibration fixture through its five measurement configurations at one excitation frequency. For each configuration it first opens every relay for a programmable break-before-make gap. It then closes that step's relays and waits a programmable settle time. Next it fires a one-cycle trigger to an external matched-filter measurement engine. Finally it waits for that engine's done strobe and stores the complex result in the slot numbered after the step. The calibration factors are computed from the five stored results elsewhere.

The step order is fixed. Step 0 closes S4 alone, so the reference voltmeter reads the known source voltage. Step 1 closes S1 and S4 and forces the current-source output to zero. Step 2 closes S3 and S5, which drives a known current through the precision resistor into the current-to-voltage converter. Step 3 closes S2 and S5, which measures the source's output current into a virtual short. Step 4 leaves every relay open and enables a small drive current into an open circuit, so that the output impedance can be estimated. A start pulse begins the walk. A done flag marks completion. An abort input drops back to idle at any point.

Top module: `cal_switch_seq`

## Requirements
- R1: After reset all five relay outputs are open, and measTrig, busy, seqDone, forceZeroCur and lowCurEn are low. Every result slot reads zero.
- R2: A start pulse accepted in idle or done begins step 0. Steps then run in the order 0,1,2,3,4. The relay vector has bit 0 = S1 through bit 4 = S5, and the step patterns are 5'b01000, 5'b01001, 5'b10100, 5'b10010 and 5'b00000 (open circuit).
- R3: Before each step's pattern is applied, all relays are open for exactly gapCycles+1 cycles. The gap begins on the cycle after start is accepted, or on the cycle after the previous step's capture. A pattern never changes directly into a different non-zero pattern.
- R4: A step's pattern is held for settleCycles+1 cycles. measTrig is then high for exactly one cycle, with the pattern still applied.
- R5: After the trigger, the pattern is held until measDone is sampled high. On that edge measRe and measIm are stored in slot k, where k is the step index. Slot k occupies bits k*DATA_W +: DATA_W of resRe and resIm.
- R6: measDone outside the wait-for-result phase is ignored. It stores nothing and does not alter the step timing.
- R7: forceZeroCur is high exactly while the step 1 pattern is applied. lowCurEn is high exactly during step 4's settle, trigger and wait phases.
- R8: After the step 4 capture, seqDone is high, busy is low and all relays are open. This holds until the next start or abort.
- R9: A start pulse while busy is ignored and does not alter the timing.
- R10: An abort pulse returns the block to idle on the next cycle: relays open, and busy, seqDone and measTrig low. Abort wins over a start or measDone in the same cycle, and already stored slots are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Begin a calibration walk |
| abortReq | input | 1 | Return to idle with relays open |
| gapCycles | input | CNT_W | Break-before-make length minus one |
| settleCycles | input | CNT_W | Settle length minus one |
| measDone | input | 1 | Measurement engine finished |
| measRe | input | DATA_W | Real part of the measurement result |
| measIm | input | DATA_W | Imaginary part of the measurement result |
| relayCtl | output | 5 | Relay closures, bit 0 = S1 .. bit 4 = S5 |
| forceZeroCur | output | 1 | Hold the current-source output at zero |
| lowCurEn | output | 1 | Enable the small open-circuit drive |
| measTrig | output | 1 | One-cycle measurement start |
| busy | output | 1 | A walk is in progress |
| seqDone | output | 1 | All five results stored |
| resRe | output | 5*DATA_W | Stored real parts, slot k at k*DATA_W |
| resIm | output | 5*DATA_W | Stored imaginary parts, slot k at k*DATA_W |

## Verification
The bench targets zero-length gap and settle counts. A design with an off-by-one error there would drop the all-open gap or fire the trigger while the relays are still bouncing. It also pulses measDone during settle and while idle: a design that captured those pulses would store a stale result and skip a step. It pulses start mid-walk: a design that restarted would replay step 0. It aborts at random points, including during the trigger and wait phases: a design with the wrong priority would leave relays closed or raise seqDone.

// File: rtl/cal_switch_seq_pkg.sv
package cal_switch_seq_pkg;

  localparam int NUM_STEPS  = 5;
  localparam int NUM_RELAYS = 5;
  localparam int STEP_W     = $clog2(NUM_STEPS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETTLE,
    ST_TRIG,
    ST_WAIT,
    ST_DONE
  } seqState_e;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic loadGap;
    logic loadSettle;
    logic countDown;
    logic capture;
  } dpStrobe_t;

  // Relay pattern for each step: bit 0 = S1 .. bit 4 = S5.
  function automatic logic [NUM_RELAYS-1:0] relayMap(input logic [STEP_W-1:0] stepIdx);
    case (stepIdx)
      3'd0:    relayMap = 5'b01000;
      3'd1:    relayMap = 5'b01001;
      3'd2:    relayMap = 5'b10100;
      3'd3:    relayMap = 5'b10010;
      default: relayMap = 5'b00000;
    endcase
  endfunction

endpackage

// File: rtl/cal_switch_seq_ctrl.sv
module cal_switch_seq_ctrl
  import cal_switch_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  abortReq,
  input  logic                  measDone,
  input  logic                  cntZero,
  output dpStrobe_t             strobe,
  output logic [STEP_W-1:0]     stepIdx,
  output logic [NUM_RELAYS-1:0] relayCtl,
  output logic                  forceZeroCur,
  output logic                  lowCurEn,
  output logic                  measTrig,
  output logic                  busy,
  output logic                  seqDone
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seqState_e state, stateNext;
  logic [STEP_W-1:0] stepNext;
  logic closedPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepIdx <= '0;
    end else begin
      state   <= stateNext;
      stepIdx <= stepNext;
    end
  end

  always_comb begin
    stateNext = state;
    stepNext  = stepIdx;
    strobe    = '0;
    if (abortReq) begin
      stateNext = ST_IDLE;
      stepNext  = '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            stateNext      = ST_GAP;
            stepNext       = '0;
            strobe.loadGap = 1'b1;
          end
        end
        ST_GAP: begin
          if (cntZero) begin
            stateNext         = ST_SETTLE;
            strobe.loadSettle = 1'b1;
          end else begin
            strobe.countDown = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (cntZero) stateNext = ST_TRIG;
          else         strobe.countDown = 1'b1;
        end
        ST_TRIG: stateNext = ST_WAIT;
        ST_WAIT: begin
          if (measDone) begin
            strobe.capture = 1'b1;
            if (stepIdx == LAST_STEP) begin
              stateNext = ST_DONE;
            end else begin
              stateNext      = ST_GAP;
              stepNext       = stepIdx + 1'b1;
              strobe.loadGap = 1'b1;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign closedPhase  = (state == ST_SETTLE) || (state == ST_TRIG) || (state == ST_WAIT);
  assign relayCtl     = closedPhase ? relayMap(stepIdx) : '0;
  assign forceZeroCur = closedPhase && (stepIdx == STEP_W'(1));
  assign lowCurEn     = closedPhase && (stepIdx == LAST_STEP);
  assign measTrig     = (state == ST_TRIG);
  assign busy         = (state != ST_IDLE) && (state != ST_DONE);
  assign seqDone      = (state == ST_DONE);

endmodule

// File: rtl/cal_switch_seq_dp.sv
module cal_switch_seq_dp
  import cal_switch_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [STEP_W-1:0]           stepIdx,
  input  logic [CNT_W-1:0]            gapCycles,
  input  logic [CNT_W-1:0]            settleCycles,
  input  logic [DATA_W-1:0]           measRe,
  input  logic [DATA_W-1:0]           measIm,
  output logic                        cntZero,
  output logic [NUM_STEPS*DATA_W-1:0] resRe,
  output logic [NUM_STEPS*DATA_W-1:0] resIm
);

  logic [CNT_W-1:0] phaseCnt;

  // One down-counter serves both the gap and the settle phases.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  phaseCnt <= '0;
    else if (strobe.loadGap)    phaseCnt <= gapCycles;
    else if (strobe.loadSettle) phaseCnt <= settleCycles;
    else if (strobe.countDown)  phaseCnt <= phaseCnt - 1'b1;
  end

  assign cntZero = (phaseCnt == '0);

  for (genvar g = 0; g < NUM_STEPS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resRe[g*DATA_W +: DATA_W] <= '0;
        resIm[g*DATA_W +: DATA_W] <= '0;
      end else if (strobe.capture && (stepIdx == STEP_W'(g))) begin
        resRe[g*DATA_W +: DATA_W] <= measRe;
        resIm[g*DATA_W +: DATA_W] <= measIm;
      end
    end
  end

endmodule

// File: rtl/cal_switch_seq.sv
module cal_switch_seq
  import cal_switch_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic                        abortReq,
  input  logic [CNT_W-1:0]            gapCycles,
  input  logic [CNT_W-1:0]            settleCycles,
  input  logic                        measDone,
  input  logic [DATA_W-1:0]           measRe,
  input  logic [DATA_W-1:0]           measIm,
  output logic [NUM_RELAYS-1:0]       relayCtl,
  output logic                        forceZeroCur,
  output logic                        lowCurEn,
  output logic                        measTrig,
  output logic                        busy,
  output logic                        seqDone,
  output logic [NUM_STEPS*DATA_W-1:0] resRe,
  output logic [NUM_STEPS*DATA_W-1:0] resIm
);

  dpStrobe_t         strobe;
  logic [STEP_W-1:0] stepIdx;
  logic              cntZero;

  cal_switch_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .abortReq     (abortReq),
    .measDone     (measDone),
    .cntZero      (cntZero),
    .strobe       (strobe),
    .stepIdx      (stepIdx),
    .relayCtl     (relayCtl),
    .forceZeroCur (forceZeroCur),
    .lowCurEn     (lowCurEn),
    .measTrig     (measTrig),
    .busy         (busy),
    .seqDone      (seqDone)
  );

  cal_switch_seq_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .stepIdx      (stepIdx),
    .gapCycles    (gapCycles),
    .settleCycles (settleCycles),
    .measRe       (measRe),
    .measIm       (measIm),
    .cntZero      (cntZero),
    .resRe        (resRe),
    .resIm        (resIm)
  );

endmodule

// File: rtl/cal_switch_seq_chk.sv
module cal_switch_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       abortReq,
  input logic       measDone,
  input logic [4:0] relayCtl,
  input logic       forceZeroCur,
  input logic       lowCurEn,
  input logic       measTrig,
  input logic       busy,
  input logic       seqDone
);

  // R3: a closed pattern only ever returns to all-open, never to another pattern
  a_r3_break_before_make: assert property (@(posedge clk) disable iff (!rstN)
    ($past(relayCtl) != 5'b0 && relayCtl != 5'b0) |-> relayCtl == $past(relayCtl));

  // R2: no pattern closes more than two relays
  a_r2_max_two_closed: assert property (@(posedge clk) disable iff (!rstN)
    $countones(relayCtl) <= 2);

  // R4: the trigger is a single-cycle pulse issued while busy
  a_r4_trig_pulse: assert property (@(posedge clk) disable iff (!rstN)
    measTrig |=> !measTrig);
  a_r4_trig_busy: assert property (@(posedge clk) disable iff (!rstN)
    measTrig |-> busy);

  // R7: zero-current only with S1+S4, low drive only with every relay open
  a_r7_force_zero_pattern: assert property (@(posedge clk) disable iff (!rstN)
    forceZeroCur |-> relayCtl == 5'b01001);
  a_r7_low_cur_open: assert property (@(posedge clk) disable iff (!rstN)
    lowCurEn |-> (relayCtl == 5'b0 && busy));

  // R8: done is an idle state, entered only from the open-circuit step's capture
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (!busy && relayCtl == 5'b0 && !measTrig));
  a_r8_done_after_final: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> ($past(measDone) && $past(lowCurEn)));

  // R10: abort lands in idle on the next cycle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !seqDone && relayCtl == 5'b0 && !measTrig));

  // R9: a start while busy does not restart the walk into a fresh gap from done
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !abortReq) |=> !seqDone || $past(measDone));

endmodule

bind cal_switch_seq cal_switch_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startReq     (startReq),
  .abortReq     (abortReq),
  .measDone     (measDone),
  .relayCtl     (relayCtl),
  .forceZeroCur (forceZeroCur),
  .lowCurEn     (lowCurEn),
  .measTrig     (measTrig),
  .busy         (busy),
  .seqDone      (seqDone)
);

// File: tb/cal_switch_seq_bench.sv
`timescale 1ns/1ps
module cal_switch_seq_bench;

  localparam int CNT_W  = 16;
  localparam int DATA_W = 24;
  localparam int NSTEP  = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                    rstN = 1'b0;
  logic                    startReq = 1'b0;
  logic                    abortReq = 1'b0;
  logic [CNT_W-1:0]        gapCycles = '0;
  logic [CNT_W-1:0]        settleCycles = '0;
  logic                    measDone = 1'b0;
  logic [DATA_W-1:0]       measRe = '0;
  logic [DATA_W-1:0]       measIm = '0;
  logic [4:0]              relayCtl;
  logic                    forceZeroCur, lowCurEn, measTrig, busy, seqDone;
  logic [NSTEP*DATA_W-1:0] resRe, resIm;

  cal_switch_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cal_switch_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .gapCycles(gapCycles), .settleCycles(settleCycles), .measDone(measDone),
    .measRe(measRe), .measIm(measIm), .relayCtl(relayCtl),
    .forceZeroCur(forceZeroCur), .lowCurEn(lowCurEn), .measTrig(measTrig),
    .busy(busy), .seqDone(seqDone), .resRe(resRe), .resIm(resIm)
  );

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] expRe [NSTEP];
  logic [DATA_W-1:0] expIm [NSTEP];

  function automatic logic [4:0] expPattern(int s);
    case (s)
      0:       return 5'b01000;
      1:       return 5'b01001;
      2:       return 5'b10100;
      3:       return 5'b10010;
      default: return 5'b00000;
    endcase
  endfunction

  // {relayCtl, measTrig, busy, seqDone, forceZeroCur, lowCurEn}
  function automatic logic [9:0] expOut(logic [4:0] rel, bit trig, bit bsy, bit dn, bit fz, bit lc);
    return {rel, trig, bsy, dn, fz, lc};
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(string tag, logic [9:0] exp);
    check(tag, {relayCtl, measTrig, busy, seqDone, forceZeroCur, lowCurEn}, exp);
  endtask

  task automatic checkSlots(string tag);
    for (int s = 0; s < NSTEP; s++) begin
      check({tag, " re"}, resRe[s*DATA_W +: DATA_W], expRe[s]);
      check({tag, " im"}, resIm[s*DATA_W +: DATA_W], expIm[s]);
    end
  endtask

  // Full walk; noise pulses a stray start and a stray measDone mid-walk.
  task automatic runSeq(int gap, int settle, bit noise);
    @(negedge clk);
    gapCycles = CNT_W'(gap);
    settleCycles = CNT_W'(settle);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int s = 0; s < NSTEP; s++) begin
      for (int i = 0; i <= gap; i++) begin
        checkOut("R3 gap all open", expOut(5'b0, 0, 1, 0, 0, 0));
        if (noise && i == 0) startReq = 1'b1;  // R9 stray start while busy
        @(negedge clk);
        startReq = 1'b0;
      end
      for (int i = 0; i <= settle; i++) begin
        checkOut("R2 R4 R7 settle pattern",
                 expOut(expPattern(s), 0, 1, 0, s == 1, s == 4));
        if (noise && i == 0) begin  // R6 stray measDone during settle
          measDone = 1'b1;
          measRe = DATA_W'($urandom);
          measIm = DATA_W'($urandom);
        end
        @(negedge clk);
        measDone = 1'b0;
      end
      checkOut("R4 trigger pulse", expOut(expPattern(s), 1, 1, 0, s == 1, s == 4));
      @(negedge clk);
      begin
        int d = $urandom_range(0, 4);
        for (int i = 0; i < d; i++) begin
          checkOut("R5 hold while waiting", expOut(expPattern(s), 0, 1, 0, s == 1, s == 4));
          @(negedge clk);
        end
      end
      checkOut("R5 wait before done", expOut(expPattern(s), 0, 1, 0, s == 1, s == 4));
      measDone = 1'b1;
      measRe = DATA_W'($urandom);
      measIm = DATA_W'($urandom);
      expRe[s] = measRe;
      expIm[s] = measIm;
      @(negedge clk);
      measDone = 1'b0;
    end
    checkOut("R8 done state", expOut(5'b0, 0, 0, 1, 0, 0));
    checkSlots("R5 stored slot");
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NSTEP; s++) begin
      expRe[s] = '0;
      expIm[s] = '0;
    end
    repeat (3) @(negedge clk);
    checkOut("R1 reset outputs", expOut(5'b0, 0, 0, 0, 0, 0));
    checkSlots("R1 reset slots");
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 idle after reset", expOut(5'b0, 0, 0, 0, 0, 0));

    // R6: measDone while idle stores nothing
    measDone = 1'b1; measRe = 24'hABCDEF; measIm = 24'h123456;
    @(negedge clk);
    measDone = 1'b0;
    checkSlots("R6 idle measDone ignored");

    // Directed corners: zero gap and settle, then larger ones
    runSeq(0, 0, 0);
    repeat (4) @(negedge clk);
    checkOut("R8 done held", expOut(5'b0, 0, 0, 1, 0, 0));
    runSeq(0, 0, 1);
    runSeq(3, 0, 1);
    runSeq(0, 5, 1);

    // Random walks, each followed by a random abort test
    for (int n = 0; n < 20; n++) begin
      runSeq($urandom_range(0, 12), $urandom_range(0, 20), n[0]);
      @(negedge clk);
      gapCycles = CNT_W'($urandom_range(0, 6));
      settleCycles = CNT_W'($urandom_range(0, 6));
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      repeat ($urandom_range(0, 60)) @(negedge clk);
      abortReq = 1'b1;
      startReq = n[1];   // R10 abort wins over start
      measDone = 1'b1;   // R10 abort wins over measDone
      measRe = DATA_W'($urandom);
      measIm = DATA_W'($urandom);
      @(negedge clk);
      abortReq = 1'b0;
      startReq = 1'b0;
      measDone = 1'b0;
      checkOut("R10 abort to idle", expOut(5'b0, 0, 0, 0, 0, 0));
      repeat (3) @(negedge clk);
      checkOut("R10 stays idle", expOut(5'b0, 0, 0, 0, 0, 0));
    end
    // R10: slots from the last complete walk survive the aborts
    checkSlots("R10 slots kept after abort");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

endmodule